// File: doc/BRIEF.md
# Memory-Mapped LED Blink Controller

This block connects sixteen LEDs to a simple synchronous peripheral bus. A request is a single cycle with request, write enable, address and write data, and it is taken on the rising clock edge. Software writes the pattern to show into a value register. A one-bit mode register selects how the pattern appears. With the mode off, the LEDs show the pattern steadily. With the mode on, they show it for one half-period and go dark for the next half-period, and this repeats.

A half-period lasts one second at the 10 MHz system clock. It is set by a parameter, so a bench can shorten it. The period counter runs only while blinking is enabled. A write of the value 1 to a reset offset returns every register to its power-on state, the same as the synchronous reset input does. Read data is registered and changes only when a supported read is taken.

Top module: `led_blink_ctrl`

## Requirements
- R1: A write to offset 0x00 stores write-data bits [15:0] into the value register and discards the upper bits. A read of 0x00 returns that value zero-extended to 32 bits.
- R2: A write to offset 0x04 stores write-data bit 0 as the blink flag and discards the other bits. A read of 0x04 returns the flag in bit 0, with zeros above it.
- R3: While the blink flag is 0, led_o equals the value register, and the period counter stays at zero.
- R4: In the cycle after the blink flag goes from 0 to 1, led_o shows the value for HALF_PERIOD cycles and then shows zero for HALF_PERIOD cycles. The pattern repeats with a period of 2*HALF_PERIOD cycles.
- R5: A write of exactly 1 to offset 0x24 clears the value register, the blink flag, the period counter and the read-data register at that edge.
- R6: A write of any value other than 1 to offset 0x24 leaves every register unchanged.
- R7: read_data_o changes only on the edge that takes a read of a supported offset. It keeps its value during idle cycles and during writes.
- R8: A read of an unsupported offset leaves read_data_o unchanged. A write to an unsupported offset changes no register.
- R9: While rst_i is high at a rising edge, the value register, the blink flag, the counter and read_data_o are cleared, so led_o reads zero afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Bus request for this block |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 32 | Byte offset within the block |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| led_o | output | 16 | LED drive |

## Verification
The bench shortens the half-period to four cycles and samples led_o in every cycle across several periods. This catches a counter that starts one cycle late, that wraps at the wrong count, or that keeps running while blinking is off; each of these shifts the light and dark windows. The reset offset is written with 2 and then with 1. A decoder that ignores the data would wipe the registers on the 2, and one that misses a register would leave a stale value or a stale read word after the 1. Reads of an unmapped offset, and writes that happen between reads, check that the read register holds its value instead of loading zero or the new data.

// File: rtl/led_blink_ctrl.sv
module led_blink_ctrl #(
  parameter int unsigned HALF_PERIOD = 10_000_000,
  parameter int unsigned NUM_LEDS    = 16,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 32,
  parameter logic [31:0] OFS_VALUE   = 32'h00,
  parameter logic [31:0] OFS_MODE    = 32'h04,
  parameter logic [31:0] OFS_CLEAR   = 32'h24
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NUM_LEDS-1:0] led_o
);

  localparam int unsigned FULL_PERIOD = 2 * HALF_PERIOD;
  localparam int unsigned CNT_W       = $clog2(FULL_PERIOD);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FULL_PERIOD - 1);
  localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(HALF_PERIOD);

  logic [NUM_LEDS-1:0] val_q;
  logic                mode_q;
  logic [CNT_W-1:0]    cnt_q;

  logic hit_value, hit_mode, hit_clear;
  logic wr_en, rd_en, soft_clr, wipe;

  assign hit_value = addr_i == ADDR_W'(OFS_VALUE);
  assign hit_mode  = addr_i == ADDR_W'(OFS_MODE);
  assign hit_clear = addr_i == ADDR_W'(OFS_CLEAR);
  assign wr_en     = req_i && we_i;
  assign rd_en     = req_i && !we_i;
  assign soft_clr  = wr_en && hit_clear && (wdata_i == DATA_W'(1));
  assign wipe      = rst_i || soft_clr;

  always_ff @(posedge clk_i) begin
    if (wipe) begin
      val_q  <= '0;
      mode_q <= 1'b0;
    end else if (wr_en) begin
      if (hit_value) val_q  <= wdata_i[NUM_LEDS-1:0];
      if (hit_mode)  mode_q <= wdata_i[0];
    end
  end

  always_ff @(posedge clk_i) begin
    if (wipe || !mode_q)       cnt_q <= '0;
    else if (cnt_q == CNT_LAST) cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (wipe)                 rdata_o <= '0;
    else if (rd_en && hit_value) rdata_o <= DATA_W'(val_q);
    else if (rd_en && hit_mode)  rdata_o <= DATA_W'(mode_q);
  end

  assign led_o = (!mode_q || cnt_q < CNT_HALF) ? val_q : '0;

  p_value_write_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_en && hit_value) |=> (val_q == $past(wdata_i[NUM_LEDS-1:0])));

  p_idle_counter_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (!mode_q) |=> (!mode_q || cnt_q == '0));

  p_wrap_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (mode_q && cnt_q == CNT_LAST) |=> (cnt_q == '0));

  p_soft_clear_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    soft_clr |=> (val_q == '0 && !mode_q && rdata_o == '0 && led_o == '0));

  p_rdata_hold_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    (!rd_en && !soft_clr) |=> $stable(rdata_o));

  p_bad_read_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    (rd_en && !hit_value && !hit_mode) |=> $stable(rdata_o));

endmodule

// File: tb/sim_led_blink_ctrl.sv
module sim_led_blink_ctrl;
  localparam int HP = 4;

  logic        clk = 1'b0;
  logic        rst_i = 1'b1;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [31:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [15:0] led_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_taken = 1'b0;

  always #10 clk = ~clk;

  led_blink_ctrl #(.HALF_PERIOD(HP)) u0 (
    .clk_i(clk), .rst_i(rst_i), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .led_o(led_o));

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  always @(posedge clk) rd_taken <= req_i && !we_i;

  always @(negedge clk) begin
    if (rd_taken && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(rdata_o, e, t);
    end
  end

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(input logic [31:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    req_i = 1'b0;
  endtask

  task automatic blink_window(input int cycles, input logic [15:0] v, input string tag);
    for (int k = 0; k < cycles; k++) begin
      chk({16'h0, led_o}, {16'h0, ((k % (2*HP)) < HP) ? v : 16'h0}, tag);
      @(negedge clk);
    end
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_i = 1'b0;
    chk({16'h0, led_o}, 32'h0, "R9 reset leds");
    chk(rdata_o, 32'h0, "R9 reset rdata");

    wr(32'h00, 32'hABCD_1234);
    chk({16'h0, led_o}, 32'h1234, "R3 steady value");
    rd(32'h00, 32'h0000_1234, "R1 value readback");
    rd(32'h04, 32'h0, "R2 mode reset");
    wr(32'h04, 32'hFFFF_FFFE);
    rd(32'h04, 32'h0, "R2 only bit0 stored");
    repeat (3) @(negedge clk);
    chk({16'h0, led_o}, 32'h1234, "R3 no blink when off");

    rd(32'h00, 32'h0000_1234, "R1 value again");
    wr(32'h00, 32'h0000_5A5A);
    chk(rdata_o, 32'h0000_1234, "R7 write does not touch rdata");
    repeat (2) @(negedge clk);
    chk(rdata_o, 32'h0000_1234, "R7 idle hold");
    rd(32'h08, 32'h0000_1234, "R8 unmapped read holds");
    wr(32'h0C, 32'hFFFF_FFFF);
    rd(32'h00, 32'h0000_5A5A, "R8 unmapped write ignored");
    rd(32'h04, 32'h0, "R8 mode untouched");

    wr(32'h04, 32'h1);
    blink_window(3 * 2 * HP, 16'h5A5A, "R4 blink timing");

    wr(32'h04, 32'h0);
    chk({16'h0, led_o}, 32'h5A5A, "R3 steady after disable");
    repeat (5) @(negedge clk);
    chk({16'h0, led_o}, 32'h5A5A, "R3 counter held");
    wr(32'h04, 32'h1);
    blink_window(2 * HP + 2, 16'h5A5A, "R4 restart from zero");

    wr(32'h24, 32'h2);
    rd(32'h00, 32'h0000_5A5A, "R6 value kept");
    rd(32'h04, 32'h1, "R6 mode kept");

    wr(32'h24, 32'h1);
    chk({16'h0, led_o}, 32'h0, "R5 leds cleared");
    chk(rdata_o, 32'h0, "R5 rdata cleared");
    rd(32'h00, 32'h0, "R5 value cleared");
    rd(32'h04, 32'h0, "R5 mode cleared");
    wr(32'h00, 32'h0000_00FF);
    chk({16'h0, led_o}, 32'h00FF, "R5 counter cleared steady");

    wr(32'h04, 32'h1);
    rd(32'h00, 32'h0000_00FF, "R1 load before reset");
    @(negedge clk);
    rst_i = 1'b1;
    @(negedge clk);
    rst_i = 1'b0;
    chk({16'h0, led_o}, 32'h0, "R9 leds after reset");
    chk(rdata_o, 32'h0, "R9 rdata after reset");
    rd(32'h04, 32'h0, "R9 mode after reset");

    repeat (2) @(negedge clk);
    chk(exp_q.size(), 0, "R7 all reads answered");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule